// File: doc/BRIEF.md
# Register-Dependency Stall Unit

This block sits between instruction decode and address generation in a small in-order core. A new instruction arrives as a descriptor. The block compares it with the descriptor of the instruction just ahead of it and decides how many cycles the new instruction must wait. The previous instruction is described by its destination register and three flags: whether it writes that register, whether it is a multiply, and whether it belongs to the class whose result is ready at once. The current instruction is described by up to three register uses: an address base, an address index with its scale, and a plain data source. Each use has its own valid flag.

A use that reads a register the previous instruction writes is a hit, and every hit has a cost. A multiply result costs the most whichever way it is read. For other producers the cost depends on the use. An address base or an unscaled index costs a short wait. A scaled index costs a longer one. A plain data read costs nothing. Results from the ready-at-once class never cost anything. These are address loads, immediate and quick moves, register clears, and operations whose memory operand uses auto-increment or auto-decrement; the updated address register from those modes is also ready at once. When several uses hit, the largest cost wins. Memory is taken as zero-wait, so memory accesses add nothing.

The cost appears on `stall_o` in the same cycle as the descriptor. A descriptor is accepted when `valid_i` is high and `hold_o` is low. On acceptance an internal counter loads the cost. `hold_o` then stays high for exactly that many cycles while the counter counts down to zero.

Top module: `stall_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `hold_o` is low and the counter is zero.
- R2: If the producer writes its destination, is a multiply and is not in the ready-at-once class, any valid use of that register (base, index or data) gives a cost of MUL_STALL (default 3).
- R3: For a non-multiply producer that writes its destination, a valid base use of that register gives a cost of BASE_STALL (default 2).
- R4: For a non-multiply producer, a valid index use of the destination with scale code 2'b00 (×1) gives a cost of BASE_STALL (default 2).
- R5: For a non-multiply producer, a valid index use of the destination with scale code 2'b01 (×2), 2'b10 (×4) or 2'b11 (reserved, taken as ×4) gives a cost of SCALED_STALL (default 3).
- R6: For a non-multiply producer, a valid data use of the destination gives a cost of zero.
- R7: When `prev_fast_i` is high the cost is zero, whatever the other inputs are.
- R8: When `prev_wr_i` is low, or no valid use names `prev_dst_i`, the cost is zero.
- R9: When several uses hit, `stall_o` is the largest of their costs.
- R10: After a descriptor is accepted with cost N, `hold_o` is high for exactly the next N cycles and then low; with N = 0 it stays low.
- R11: A descriptor presented while `hold_o` is high is not accepted and does not change how long the current hold lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | A new descriptor is presented |
| prev_dst_i | input | REG_W | Destination register of the previous instruction |
| prev_wr_i | input | 1 | The previous instruction writes its destination |
| prev_mul_i | input | 1 | The previous instruction is a multiply |
| prev_fast_i | input | 1 | The previous instruction's result is ready at once |
| cur_base_i | input | REG_W | Register used as the address base |
| cur_base_vld_i | input | 1 | The base use is present |
| cur_idx_i | input | REG_W | Register used as the address index |
| cur_idx_vld_i | input | 1 | The index use is present |
| cur_scale_i | input | 2 | Index scale: 00 ×1, 01 ×2, 10 ×4, 11 ×4 |
| cur_data_i | input | REG_W | Register read as a data operand |
| cur_data_vld_i | input | 1 | The data use is present |
| stall_o | output | CNT_W | Cost of the presented descriptor |
| hold_o | output | 1 | The current instruction is held |

## Verification
The checker assumes that the producer flags come from a decoder that sets at most one class per instruction. It also assumes that a ready-at-once producer may carry any multiply flag, because the ready-at-once class takes precedence in every case. It further assumes that CNT_W is wide enough for the largest cost, so a load never truncates. The stimulus keeps to these assumptions by using the default parameters. It sweeps every combination of the producer flags, the three use-valid flags, the four scale codes and the three register-match patterns. While a hold is active it presents only a hazardous multiply descriptor, which must be refused.

// File: rtl/stall_pkg.sv
package stall_pkg;

    typedef enum logic [1:0] {
        USE_BASE  = 2'd0,
        USE_INDEX = 2'd1,
        USE_DATA  = 2'd2
    } use_kind_e;

    typedef enum logic [1:0] {
        SCALE_X1   = 2'b00,
        SCALE_X2   = 2'b01,
        SCALE_X4   = 2'b10,
        SCALE_RSVD = 2'b11
    } scale_e;

    localparam int NUM_USES = 3;

    function automatic use_kind_e kind_of(input int slot);
        case (slot)
            0:       return USE_BASE;
            1:       return USE_INDEX;
            default: return USE_DATA;
        endcase
    endfunction

endpackage

// File: rtl/stall_use_match.sv
module stall_use_match #(
    parameter int REG_W = 4
) (
    input  logic [REG_W-1:0] use_reg_i,
    input  logic             use_vld_i,
    input  logic [REG_W-1:0] dst_i,
    input  logic             dst_wr_i,
    input  logic             dst_fast_i,
    output logic             hit_o
);

    always_comb begin
        hit_o = 1'b0;
        if (use_vld_i && dst_wr_i && !dst_fast_i) begin
            hit_o = (use_reg_i == dst_i);
        end
    end

endmodule

// File: rtl/stall_use_cost.sv
module stall_use_cost
    import stall_pkg::*;
#(
    parameter int CNT_W        = 3,
    parameter int BASE_STALL   = 2,
    parameter int SCALED_STALL = 3,
    parameter int MUL_STALL    = 3
) (
    input  use_kind_e        kind_i,
    input  logic [1:0]       scale_i,
    input  logic             hit_i,
    input  logic             mul_i,
    output logic [CNT_W-1:0] cost_o
);

    localparam logic [CNT_W-1:0] COST_BASE   = CNT_W'(BASE_STALL);
    localparam logic [CNT_W-1:0] COST_SCALED = CNT_W'(SCALED_STALL);
    localparam logic [CNT_W-1:0] COST_MUL    = CNT_W'(MUL_STALL);

    always_comb begin
        cost_o = '0;
        if (hit_i) begin
            if (mul_i) begin
                cost_o = COST_MUL;
            end else begin
                case (kind_i)
                    USE_BASE:  cost_o = COST_BASE;
                    USE_INDEX: cost_o = (scale_i == SCALE_X1) ? COST_BASE : COST_SCALED;
                    default:   cost_o = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/stall_countdown.sv
module stall_countdown #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             hold_o,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cd_state_t;

    cd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = (st_q.cnt != '0);
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/stall_unit.sv
module stall_unit
    import stall_pkg::*;
#(
    parameter int REG_W        = 4,
    parameter int BASE_STALL   = 2,
    parameter int SCALED_STALL = 3,
    parameter int MUL_STALL    = 3,
    parameter int CNT_W        = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [REG_W-1:0] prev_dst_i,
    input  logic             prev_wr_i,
    input  logic             prev_mul_i,
    input  logic             prev_fast_i,
    input  logic [REG_W-1:0] cur_base_i,
    input  logic             cur_base_vld_i,
    input  logic [REG_W-1:0] cur_idx_i,
    input  logic             cur_idx_vld_i,
    input  logic [1:0]       cur_scale_i,
    input  logic [REG_W-1:0] cur_data_i,
    input  logic             cur_data_vld_i,
    output logic [CNT_W-1:0] stall_o,
    output logic             hold_o
);

    logic [REG_W-1:0] use_reg [NUM_USES];
    logic             use_vld [NUM_USES];
    logic             use_hit [NUM_USES];
    logic [CNT_W-1:0] use_cost[NUM_USES];
    logic [CNT_W-1:0] worst_d;
    logic             accept;
    logic [CNT_W-1:0] cnt_w;

    assign use_reg[0] = cur_base_i;
    assign use_vld[0] = cur_base_vld_i;
    assign use_reg[1] = cur_idx_i;
    assign use_vld[1] = cur_idx_vld_i;
    assign use_reg[2] = cur_data_i;
    assign use_vld[2] = cur_data_vld_i;

    for (genvar g = 0; g < NUM_USES; g++) begin : g_use
        stall_use_match #(
            .REG_W (REG_W)
        ) u_match (
            .use_reg_i  (use_reg[g]),
            .use_vld_i  (use_vld[g]),
            .dst_i      (prev_dst_i),
            .dst_wr_i   (prev_wr_i),
            .dst_fast_i (prev_fast_i),
            .hit_o      (use_hit[g])
        );

        stall_use_cost #(
            .CNT_W        (CNT_W),
            .BASE_STALL   (BASE_STALL),
            .SCALED_STALL (SCALED_STALL),
            .MUL_STALL    (MUL_STALL)
        ) u_cost (
            .kind_i  (kind_of(g)),
            .scale_i (cur_scale_i),
            .hit_i   (use_hit[g]),
            .mul_i   (prev_mul_i),
            .cost_o  (use_cost[g])
        );
    end

    always_comb begin
        worst_d = '0;
        for (int i = 0; i < NUM_USES; i++) begin
            if (use_cost[i] > worst_d) begin
                worst_d = use_cost[i];
            end
        end
    end

    assign accept = valid_i && !hold_o;

    stall_countdown #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .load_val_i (worst_d),
        .hold_o     (hold_o),
        .cnt_o      (cnt_w)
    );

    assign stall_o = worst_d;

endmodule

// File: rtl/stall_unit_chk.sv
module stall_unit_chk #(
    parameter int REG_W     = 4,
    parameter int CNT_W     = 3,
    parameter int MUL_STALL = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             valid_i,
    input logic [REG_W-1:0] prev_dst_i,
    input logic             prev_wr_i,
    input logic             prev_mul_i,
    input logic             prev_fast_i,
    input logic [REG_W-1:0] cur_base_i,
    input logic             cur_base_vld_i,
    input logic [CNT_W-1:0] stall_o,
    input logic             hold_o,
    input logic [CNT_W-1:0] cnt_w
);

    p_reset_r1: assert property (@(posedge clk) rst |=> (!hold_o && cnt_w == '0));

    p_mul_base_r2: assert property (@(posedge clk) disable iff (rst)
        (prev_wr_i && prev_mul_i && !prev_fast_i && cur_base_vld_i && cur_base_i == prev_dst_i)
        |-> (stall_o == CNT_W'(MUL_STALL)));

    p_fast_zero_r7: assert property (@(posedge clk) disable iff (rst)
        prev_fast_i |-> (stall_o == '0));

    p_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        !prev_wr_i |-> (stall_o == '0));

    p_bound_r9: assert property (@(posedge clk) disable iff (rst)
        stall_o <= CNT_W'(MUL_STALL));

    p_load_r10: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !hold_o) |=> (cnt_w == $past(stall_o)));

    p_count_r11: assert property (@(posedge clk) disable iff (rst)
        hold_o |=> (cnt_w == $past(cnt_w) - 1'b1));

endmodule

bind stall_unit stall_unit_chk #(
    .REG_W     (REG_W),
    .CNT_W     (CNT_W),
    .MUL_STALL (MUL_STALL)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .valid_i        (valid_i),
    .prev_dst_i     (prev_dst_i),
    .prev_wr_i      (prev_wr_i),
    .prev_mul_i     (prev_mul_i),
    .prev_fast_i    (prev_fast_i),
    .cur_base_i     (cur_base_i),
    .cur_base_vld_i (cur_base_vld_i),
    .stall_o        (stall_o),
    .hold_o         (hold_o),
    .cnt_w          (cnt_w)
);

// File: tb/tb_stall_unit.sv
`timescale 1ns/1ps
module tb_stall_unit;

    localparam int REG_W = 4;
    localparam int CNT_W = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             valid_i = 1'b0;
    logic [REG_W-1:0] prev_dst_i = '0;
    logic             prev_wr_i = 1'b0, prev_mul_i = 1'b0, prev_fast_i = 1'b0;
    logic [REG_W-1:0] cur_base_i = '0, cur_idx_i = '0, cur_data_i = '0;
    logic             cur_base_vld_i = 1'b0, cur_idx_vld_i = 1'b0, cur_data_vld_i = 1'b0;
    logic [1:0]       cur_scale_i = 2'b00;
    logic [CNT_W-1:0] stall_o;
    logic             hold_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stall_unit dut (
        .clk(clk), .rst(rst), .valid_i(valid_i),
        .prev_dst_i(prev_dst_i), .prev_wr_i(prev_wr_i), .prev_mul_i(prev_mul_i),
        .prev_fast_i(prev_fast_i),
        .cur_base_i(cur_base_i), .cur_base_vld_i(cur_base_vld_i),
        .cur_idx_i(cur_idx_i), .cur_idx_vld_i(cur_idx_vld_i), .cur_scale_i(cur_scale_i),
        .cur_data_i(cur_data_i), .cur_data_vld_i(cur_data_vld_i),
        .stall_o(stall_o), .hold_o(hold_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_cost(input int c);
        bit wr, mul, fast, bv, iv, dv, bm, im, dm;
        int sc, worst, k;
        wr = c[0]; mul = c[1]; fast = c[2];
        bv = c[3]; iv = c[4]; dv = c[5];
        sc = (c >> 6) & 3;
        bm = c[8]; im = c[9]; dm = c[10];
        worst = 0;
        if (!wr || fast) return 0;
        if (bv && bm) begin k = mul ? 3 : 2; if (k > worst) worst = k; end
        if (iv && im) begin k = mul ? 3 : ((sc == 0) ? 2 : 3); if (k > worst) worst = k; end
        if (dv && dm) begin k = mul ? 3 : 0; if (k > worst) worst = k; end
        return worst;
    endfunction

    function automatic string req_of(input int c);
        int hits;
        if (c[2]) return "R7";
        if (!c[0]) return "R8";
        hits = (c[3] & c[8]) + (c[4] & c[9]) + (c[5] & c[10]);
        if (hits == 0) return "R8";
        if (hits > 1) return "R9";
        if (c[1]) return "R2";
        if (c[3] & c[8]) return "R3";
        if (c[5] & c[10]) return "R6";
        return (((c >> 6) & 3) == 0) ? "R4" : "R5";
    endfunction

    task automatic apply(input int c);
        prev_dst_i     = 4'd5;
        prev_wr_i      = c[0];
        prev_mul_i     = c[1];
        prev_fast_i    = c[2];
        cur_base_vld_i = c[3];
        cur_idx_vld_i  = c[4];
        cur_data_vld_i = c[5];
        cur_scale_i    = 2'((c >> 6) & 3);
        cur_base_i     = c[8]  ? 4'd5 : 4'd9;
        cur_idx_i      = c[9]  ? 4'd5 : 4'd10;
        cur_data_i     = c[10] ? 4'd5 : 4'd11;
    endtask

    task automatic apply_junk();
        prev_dst_i = 4'd5; prev_wr_i = 1'b1; prev_mul_i = 1'b1; prev_fast_i = 1'b0;
        cur_base_i = 4'd5; cur_base_vld_i = 1'b1;
        cur_idx_i = 4'd5; cur_idx_vld_i = 1'b1; cur_scale_i = 2'b10;
        cur_data_i = 4'd5; cur_data_vld_i = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(hold_o == 1'b0, "R1 hold in reset", hold_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(hold_o == 1'b0, "R1 hold after reset", hold_o, 0);

        for (int c = 0; c < 2048; c++) begin
            int exp, n;
            exp = expect_cost(c);
            apply(c);
            valid_i = 1'b1;
            #1;
            check(int'(stall_o) == exp, req_of(c), stall_o, exp);
            @(posedge clk);
            @(negedge clk);
            apply_junk();
            n = 0;
            for (int w = 0; w < 8; w++) begin
                if (!hold_o) break;
                n++;
                @(negedge clk);
            end
            valid_i = 1'b0;
            check(n == exp, (exp != 0 && c[1]) ? "R10 R11 hold length" : "R10 hold length", n, exp);
            @(negedge clk);
            check(hold_o == 1'b0, "R10 hold released", hold_o, 0);
        end

        rst = 1'b1;
        apply(11'h10B);
        valid_i = 1'b1;
        @(negedge clk);
        check(hold_o == 1'b0, "R1 reset overrides load", hold_o, 0);
        valid_i = 1'b0;
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule